// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block decides which interrupt a processor core should take next. Fifteen request lines arrive already latched by their peripherals. Each line is qualified by its own enable bit and by a global enable. A per-source level bit places each source at either the high or the low priority level. Among the eligible requests the block picks one winner. It then presents that source's program-memory vector address together with a request strobe. The vector is held steady until the core acknowledges it.

The block keeps one in-service flag per level, so it knows which routines are currently nested. An acknowledge marks the presented level as in service. A return pulse retires the deepest active level. A low-level routine can be interrupted only by a high-level request, and a high-level routine cannot be interrupted at all.

Within a level, ties are settled by a fixed polling sequence. This sequence interleaves the sources and does not follow vector order. It is generated from a lane/step arrangement of the source indices and is not stored as a table.

Top module: `dual_level_irq_ctrl`

## Requirements
- R1: Source i (bit i of every per-source vector, i = 0..14) is presented with vector address 0x0003 + 8*i, giving 0x0003 for bit 0 up to 0x0073 for bit 14.
- R2: A source takes part in arbitration only when its request bit, its enable bit and the global enable are all 1. If any of the three is 0, that source is never presented.
- R3: If eligible requests exist at both levels (level bit 1 = high, 0 = low), the high-level winner is presented.
- R4: Within one level, the winner is the first eligible bit in this bit-index sequence: 0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14.
- R5: The strobe and vector are registered. They appear one clock after an eligible request is sampled while no strobe is up. They then stay unchanged, whatever the request inputs do, until an acknowledge is sampled.
- R6: An acknowledge sampled while the strobe is up does two things: it sets the in-service flag of the presented level, and it drops the strobe on the next clock. An acknowledge while the strobe is down has no effect.
- R7: While only the low in-service flag is set, only a high-level source can be presented.
- R8: While the high in-service flag is set, nothing is presented.
- R9: A return pulse clears the high in-service flag if it is set, and otherwise clears the low flag. When a return and an acknowledge arrive in the same cycle, the clearing uses the flags as they were before that cycle, and the acknowledge then sets its level's flag.
- R10: Reset clears both in-service flags and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | 15 | Latched request bit per source |
| srcEn | input | 15 | Enable bit per source |
| srcHigh | input | 15 | Level bit per source (1 = high) |
| globalEn | input | 1 | Global enable for all sources |
| ack | input | 1 | Acknowledge pulse from the core |
| reti | input | 1 | Return-from-interrupt pulse |
| vecValid | output | 1 | Interrupt request strobe to the core |
| vecAddr | output | 16 | Vector address of the presented source |
| vecHigh | output | 1 | Level of the presented source |
| inService | output | 2 | In-service flags: bit 1 high, bit 0 low |

## Verification
The bench builds the block with its default parameters: 15 sources in 3 lanes of 5, a 16-bit vector, a base of 3 and a stride of 8. With these values every source index and every lane of the interleaved polling sequence can be reached. Every vector from 0x0003 up to 0x0073 can also be produced. All four combinations of the in-service flags can be reached, including a return and an acknowledge landing in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef struct packed {
    logic load;
    logic pickHigh;
  } irqcStrobe_t;

  // Polling rank r lives in lane (r % lanes), step (r / lanes);
  // the source index is lane * perLane + step.
  function automatic int rankToIdx(input int rank, input int lanes, input int perLane);
    return (rank % lanes) * perLane + (rank / lanes);
  endfunction

endpackage

// File: rtl/irqc_picker.sv
module irqc_picker #(
  parameter int NUM_SRC = 15,
  parameter int LANES   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int PER_LANE = NUM_SRC / LANES
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   winIdx
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] byRank;
  logic [IDX_W-1:0]   idxOfRank [NUM_SRC];

  for (genvar r = 0; r < NUM_SRC; r++) begin : g_rank
    localparam int SRC = rankToIdx(r, LANES, PER_LANE);
    assign byRank[r]    = cand[SRC];
    assign idxOfRank[r] = IDX_W'(SRC);
  end

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (byRank[r]) begin
        found  = 1'b1;
        winIdx = idxOfRank[r];
      end
    end
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath #(
  parameter int NUM_SRC  = 15,
  parameter int LANES    = 3,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     irqReq,
  input  logic [NUM_SRC-1:0]     srcEn,
  input  logic [NUM_SRC-1:0]     srcHigh,
  input  logic                   globalEn,
  input  irqc_pkg::irqcStrobe_t  strobe,
  output logic                   anyHigh,
  output logic                   anyLow,
  output logic [VEC_W-1:0]       vecAddr,
  output logic                   vecHigh
);

  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] levelCand [2];
  logic               levelFound [2];
  logic [IDX_W-1:0]   levelIdx [2];
  logic [IDX_W-1:0]   selIdx;
  logic [VEC_W-1:0]   nextVec;

  assign eligible     = irqReq & srcEn & {NUM_SRC{globalEn}};
  assign levelCand[0] = eligible & ~srcHigh;
  assign levelCand[1] = eligible & srcHigh;

  for (genvar lv = 0; lv < 2; lv++) begin : g_level
    irqc_picker #(.NUM_SRC(NUM_SRC), .LANES(LANES)) u_pick (
      .cand  (levelCand[lv]),
      .found (levelFound[lv]),
      .winIdx(levelIdx[lv])
    );
  end

  assign anyLow  = levelFound[0];
  assign anyHigh = levelFound[1];
  assign selIdx  = strobe.pickHigh ? levelIdx[1] : levelIdx[0];
  assign nextVec = VEC_W'(VEC_BASE) + VEC_W'(selIdx) * VEC_W'(VEC_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecAddr <= '0;
      vecHigh <= 1'b0;
    end else if (strobe.load) begin
      vecAddr <= nextVec;
      vecHigh <= strobe.pickHigh;
    end
  end

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  anyHigh,
  input  logic                  anyLow,
  input  logic                  vecHigh,
  input  logic                  ack,
  input  logic                  reti,
  output irqc_pkg::irqcStrobe_t strobe,
  output logic                  vecValid,
  output logic [1:0]            inSvc
);

  logic       allowHigh;
  logic       allowLow;
  logic       grantHigh;
  logic       grantLow;
  logic       takeAck;
  logic [1:0] svcAfterRet;
  logic [1:0] svcNext;

  always_comb begin
    allowHigh       = !inSvc[1];
    allowLow        = (inSvc == 2'b00);
    grantHigh       = anyHigh && allowHigh;
    grantLow        = !grantHigh && anyLow && allowLow;
    strobe.load     = !vecValid && (grantHigh || grantLow);
    strobe.pickHigh = grantHigh;
  end

  always_comb begin
    takeAck     = vecValid && ack;
    svcAfterRet = inSvc;
    if (reti) begin
      if (inSvc[1]) svcAfterRet[1] = 1'b0;
      else          svcAfterRet[0] = 1'b0;
    end
    svcNext = svcAfterRet;
    if (takeAck) begin
      if (vecHigh) svcNext[1] = 1'b1;
      else         svcNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecValid <= 1'b0;
      inSvc    <= 2'b00;
    end else begin
      inSvc <= svcNext;
      if (takeAck)          vecValid <= 1'b0;
      else if (strobe.load) vecValid <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_level_irq_ctrl.sv
module dual_level_irq_ctrl #(
  parameter int NUM_SRC  = 15,
  parameter int LANES    = 3,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  logic               globalEn,
  input  logic               ack,
  input  logic               reti,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               vecHigh,
  output logic [1:0]         inService
);

  irqc_pkg::irqcStrobe_t strobe;
  logic anyHigh;
  logic anyLow;

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .LANES(LANES), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk, .rst_n, .irqReq, .srcEn, .srcHigh, .globalEn,
    .strobe, .anyHigh, .anyLow, .vecAddr, .vecHigh
  );

  irqc_ctrl u_ctrl (
    .clk, .rst_n, .anyHigh, .anyLow, .vecHigh, .ack, .reti,
    .strobe, .vecValid, .inSvc(inService)
  );

endmodule

// File: rtl/dual_level_irq_ctrl_chk.sv
module dual_level_irq_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             reti,
  input logic             vecValid,
  input logic [VEC_W-1:0] vecAddr,
  input logic             vecHigh,
  input logic [1:0]       inService
);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid && !ack |=> vecValid && $stable(vecAddr) && $stable(vecHigh));

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid && ack |=> !vecValid);

  p_ack_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid && ack && !reti && vecHigh |=> inService[1]);

  p_ack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid && ack && !reti && !vecHigh |=> inService[0]);

  p_low_only_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inService == 2'b01 && !vecValid |=> !vecValid || vecHigh);

  p_high_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inService[1] && !vecValid |=> !vecValid);

  p_reti_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(vecValid && ack) && inService == 2'b11 |=> inService == 2'b01);

endmodule

bind dual_level_irq_ctrl dual_level_irq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk, .rst_n, .ack, .reti, .vecValid, .vecAddr, .vecHigh, .inService
);

// File: tb/dual_level_irq_ctrl_tb.sv
module dual_level_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irqReq = '0;
  logic [N-1:0] srcEn = '0;
  logic [N-1:0] srcHigh = '0;
  logic         globalEn = 1'b0;
  logic         ack = 1'b0;
  logic         reti = 1'b0;
  logic         vecValid;
  logic [15:0]  vecAddr;
  logic         vecHigh;
  logic [1:0]   inService;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // model state
  bit        mValid = 1'b0;
  bit [15:0] mAddr = '0;
  bit        mHigh = 1'b0;
  bit [1:0]  mSvc = 2'b00;

  int pollOrder [N] = '{0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14};

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_level_irq_ctrl u_dut (
    .clk, .rst_n, .irqReq, .srcEn, .srcHigh, .globalEn, .ack, .reti,
    .vecValid, .vecAddr, .vecHigh, .inService
  );

  function automatic int firstInOrder(input logic [N-1:0] c);
    for (int k = 0; k < N; k++) if (c[pollOrder[k]]) return pollOrder[k];
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic cmpAll(input string tag);
    check(tag, "strobe", int'(vecValid), int'(mValid));
    if (mValid) begin
      check(tag, "vector", int'(vecAddr), int'(mAddr));
      check(tag, "level", int'(vecHigh), int'(mHigh));
    end
    check(tag, "inService", int'(inService), int'(mSvc));
  endtask

  // Advance one clock with the currently driven inputs, then compare.
  task automatic step(input string tag);
    bit        nValid = mValid;
    bit [15:0] nAddr = mAddr;
    bit        nHigh = mHigh;
    bit [1:0]  nSvc = mSvc;
    logic [N-1:0] elig = irqReq & srcEn & {N{globalEn}};
    int hi = firstInOrder(elig & srcHigh);
    int lo = firstInOrder(elig & ~srcHigh);
    if (!rst_n) begin
      nValid = 0; nSvc = 0;
    end else begin
      if (reti) begin
        if (mSvc[1]) nSvc[1] = 0; else nSvc[0] = 0;
      end
      if (mValid && ack) begin
        nSvc[mHigh] = 1;
        nValid = 0;
      end else if (!mValid) begin
        if (hi >= 0 && !mSvc[1]) begin
          nValid = 1; nHigh = 1; nAddr = 16'(3 + 8 * hi);
        end else if (lo >= 0 && mSvc == 2'b00) begin
          nValid = 1; nHigh = 0; nAddr = 16'(3 + 8 * lo);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    mValid = nValid; mAddr = nAddr; mHigh = nHigh; mSvc = nSvc;
    cmpAll(tag);
  endtask

  // acknowledge the presented source and drop its request
  task automatic takeIt(input string tag);
    ack = 1;
    if (mValid) irqReq[(mAddr - 3) / 8] = 1'b0;
    step(tag);
    ack = 0;
  endtask

  task automatic retOnce(input string tag);
    reti = 1;
    step(tag);
    reti = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    step("R10");
    step("R10");
    rst_n = 1;
    srcEn = '1;
    globalEn = 1;

    // R1: every source alone at the low level
    for (int i = 0; i < N; i++) begin
      irqReq = '0;
      irqReq[i] = 1'b1;
      step("R1");
      takeIt("R6");
      retOnce("R9");
    end

    // R2: global enable off, then per-source enable off
    irqReq = '1;
    globalEn = 0;
    step("R2");
    step("R2");
    globalEn = 1;
    srcEn = '0;
    step("R2");
    srcEn = '1;

    // R3 / R8: one high source among many low ones
    srcHigh = '0;
    srcHigh[14] = 1'b1;
    step("R3");
    takeIt("R6");
    step("R8");
    step("R8");
    retOnce("R9");

    // R4: drain all low sources one by one in polling order
    srcHigh = '0;
    irqReq = '1;
    for (int k = 0; k < N; k++) begin
      step("R4");
      takeIt("R4");
      retOnce("R9");
    end

    // R7 / R9: low in service, then a high and a low request
    irqReq = '0;
    irqReq[0] = 1'b1;
    step("R7");
    takeIt("R7");
    irqReq[3] = 1'b1;
    irqReq[7] = 1'b1;
    srcHigh[7] = 1'b1;
    step("R7");
    takeIt("R7");
    step("R8");
    retOnce("R9");
    retOnce("R9");
    step("R9");

    // R5: hold while unacknowledged, inputs changing
    irqReq = 16'h0 | (15'b1 << 12);
    srcHigh = '0;
    step("R5");
    irqReq = '1;
    srcHigh = '1;
    step("R5");
    globalEn = 0;
    step("R5");
    globalEn = 1;
    takeIt("R5");
    // return and acknowledge together
    step("R9");
    ack = 1;
    reti = 1;
    if (mValid) irqReq[(mAddr - 3) / 8] = 1'b0;
    step("R9");
    ack = 0;
    reti = 0;
    retOnce("R9");
    retOnce("R9");

    // Random traffic
    irqReq = '0;
    for (int c = 0; c < 4000; c++) begin
      if (c % 200 == 0) begin
        srcHigh = N'($urandom);
        srcEn = N'($urandom) | N'($urandom);
      end
      globalEn = ($urandom % 20) != 0;
      for (int b = 0; b < N; b++) if ($urandom % 25 == 0) irqReq[b] = 1'b1;
      reti = ($urandom % 8) == 0;
      ack = mValid && ($urandom % 5 < 2);
      if (ack) irqReq[(mAddr - 3) / 8] = 1'b0;
      step("R4");
    end
    ack = 0;
    reti = 0;

    rst_n = 0;
    step("R10");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule